// File: doc/BRIEF.md
# I2C Master Bit Timing Engine

This block produces the clock line waveform and drives the data line for a single I2C master, one bus condition or one bit at a time. A byte-level sequencer above it asks for a START, a repeated START, a bit write (data or acknowledge), a bit read, or a STOP. The block then walks a seven-state clock machine. Every phase length comes from a configuration input and is counted in module clock cycles.

Both lines are open drain. An output enable that is high pulls its line low. The block reads the real line levels back, so a slave that holds the clock line low extends the rising-edge phase. After each bit the engine parks with the clock line released, and it waits there for the next request. Each completed request returns a one-cycle done pulse together with the last sampled data-line value. A stuck-state watchdog pulses when the machine stays in one working state for too long.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset the state output is Idle (0), both output enables are low, `req_ready` is high, and `op_done` and `stuck_pulse` are low. The state output only takes the codes 0 Idle, 1 Start, 2 Negative edge, 3 Low, 4 Positive edge, 5 High and 6 Stop.
- R2: A START request (op code 0) accepted in Idle enters Start. In Start, SDA is pulled low while SCL stays released for `cfg_start_hold` cycles. The request then completes in parked High (5) with SDA pulled and SCL released.
- R3: A WRITE request (op code 2) from parked High spends `cfg_hold` cycles in Negative edge and `cfg_low` cycles in Low, with `sda_oe` equal to the inverse of `req_bit`. It then passes through Positive edge and spends `cfg_high` cycles in High before `op_done`. The SDA drive level persists while parked.
- R4: `sda_oe` does not change during Negative edge; the new data level appears only on entry to Low.
- R5: A READ request (op code 3) releases SDA for the bit. With `sample_on_low` = 0, `rx_bit` is the SDA line level `cfg_sample` cycles after entering High. A WRITE also reports the line level read back.
- R6: With `sample_on_low` = 1, SDA is sampled `cfg_sample` cycles after entering Low instead.
- R7: Positive edge does not end while SCL reads low, so a slave that stretches the clock lengthens this state cycle for cycle.
- R8: Positive edge lasts at least `cfg_wait_high` cycles even when SCL reads high at once.
- R9: A repeated START request (op code 1) from parked High runs Negative edge, then Low with SDA released, then Positive edge. It then spends `cfg_rstart_setup` cycles in Start with SDA released and `cfg_start_hold` cycles in Start with SDA pulled, and completes in parked High.
- R10: A STOP request (op code 4) from parked High runs Negative edge, then Low with SDA pulled, then Positive edge. It then spends `cfg_stop_setup` cycles in Stop with SDA pulled and `cfg_stop_hold` cycles in Stop with SDA released, and completes in Idle with both lines released.
- R11: Idle accepts only START, and parked High accepts every request except START. An ignored request leaves the state and line drives unchanged and produces no `op_done`. `req_ready` is high exactly in Idle and parked High.
- R12: While working (not Idle, not parked), `stuck_pulse` pulses once for every 2^`wdt_exp` cycles spent without a state change, counting restarts on every state change, and a `wdt_exp` above 23 acts as 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high and the code is legal |
| req_op | input | 3 | 0 START, 1 repeated START, 2 WRITE, 3 READ, 4 STOP |
| req_bit | input | 1 | Bit to write |
| req_ready | output | 1 | High in Idle and in parked High |
| cfg_hold | input | 9 | SDA hold cycles after SCL falls |
| cfg_low | input | 9 | Low state cycles |
| cfg_high | input | 9 | High state cycles |
| cfg_sample | input | 9 | Sample offset into High or Low |
| cfg_start_hold | input | 9 | SDA-fall to SCL-fall delay |
| cfg_rstart_setup | input | 9 | SCL-high to SDA-fall delay for repeated START |
| cfg_stop_setup | input | 9 | SCL-high to SDA-rise delay for STOP |
| cfg_stop_hold | input | 9 | Bus hold after STOP |
| cfg_wait_high | input | 7 | Minimum Positive edge cycles |
| sample_on_low | input | 1 | 0 samples in High, 1 samples in Low |
| wdt_exp | input | 5 | Watchdog exponent |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| op_done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Last sampled SDA level |
| scl_state | output | 3 | Current clock machine state |
| stuck_pulse | output | 1 | Watchdog pulse |

## Verification
A wrong state shows on `scl_state` in the same cycle, and it shows as a wrong phase length by the time `op_done` arrives, one cycle after the last phase ends. A wrong data drive shows on `sda_oe` at once and is still visible in the parked High that follows. A wrong sample point changes `rx_bit` at the done pulse whenever the slave drives different levels in Low and High. A miscounted watchdog shows as a wrong number of `stuck_pulse` cycles within one long Low phase.

// File: rtl/i2c_bit_timer_pkg.sv
package i2c_bit_timer_pkg;
  localparam int TIME_W  = 9;
  localparam int WAIT_W  = 7;
  localparam int WDT_W   = 5;
  localparam int WDT_MAX = 23;
  localparam int ST_W    = 3;
  localparam int CNT_W   = TIME_W + 1;
  localparam int WDC_W   = WDT_MAX + 1;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_NEG   = 3'd2,
    ST_LOW   = 3'd3,
    ST_POS   = 3'd4,
    ST_HIGH  = 3'd5,
    ST_STOP  = 3'd6
  } scl_st_e;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } bit_op_e;

  typedef struct packed {
    logic [TIME_W-1:0] hold;
    logic [TIME_W-1:0] low;
    logic [TIME_W-1:0] high;
    logic [TIME_W-1:0] sample;
    logic [TIME_W-1:0] start_hold;
    logic [TIME_W-1:0] rstart_setup;
    logic [TIME_W-1:0] stop_setup;
    logic [TIME_W-1:0] stop_hold;
    logic [WAIT_W-1:0] wait_high;
  } timing_t;
endpackage

// File: rtl/i2c_bit_timer_fsm.sv
module i2c_bit_timer_fsm
  import i2c_bit_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic              req_bit,
  input  timing_t           cfg,
  input  logic              sample_on_low,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              ready,
  output logic              done,
  output logic              rx_bit,
  output logic [ST_W-1:0]   state
);
  scl_st_e           st_q, st_d;
  bit_op_e           op_q, op_d;
  logic              phase_q, phase_d;
  logic              parked_q, parked_d;
  logic              bit_q, bit_d;
  logic              pull_q, pull_d;
  logic              done_q, done_d;
  logic              rx_q, rx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              legal, accept, sample_hit;

  // A phase of length p occupies max(p,1) cycles.
  function automatic logic elapsed(input logic [CNT_W-1:0] c, input logic [TIME_W-1:0] p);
    logic [CNT_W:0] c1;
    c1 = {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
    return c1 >= {{(CNT_W+1-TIME_W){1'b0}}, p};
  endfunction

  assign ready = (st_q == ST_IDLE) || (st_q == ST_HIGH && parked_q);
  assign legal = (st_q == ST_IDLE) ? (req_op == OP_START)
                                   : (req_op inside {OP_RSTART, OP_WRITE, OP_READ, OP_STOP});
  assign accept = req_valid && ready && legal;
  assign sample_hit = (sample_on_low ? (st_q == ST_LOW) : (st_q == ST_HIGH && !parked_q))
                      && (cnt_q == {1'b0, cfg.sample});

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    phase_d  = phase_q;
    parked_d = parked_q;
    bit_d    = bit_q;
    pull_d   = pull_q;
    done_d   = 1'b0;
    rx_d     = sample_hit ? sda_in : rx_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d = ST_START; phase_d = 1'b1; pull_d = 1'b1; op_d = bit_op_e'(req_op);
      end
      ST_START: begin
        if (!phase_q) begin
          if (elapsed(cnt_q, cfg.rstart_setup)) begin phase_d = 1'b1; pull_d = 1'b1; end
        end else if (elapsed(cnt_q, cfg.start_hold)) begin
          st_d = ST_HIGH; parked_d = 1'b1; done_d = 1'b1;
        end
      end
      ST_NEG: if (elapsed(cnt_q, cfg.hold)) begin
        st_d = ST_LOW;
        case (op_q)
          OP_WRITE: pull_d = !bit_q;
          OP_STOP:  pull_d = 1'b1;
          default:  pull_d = 1'b0;
        endcase
      end
      ST_LOW: if (elapsed(cnt_q, cfg.low)) st_d = ST_POS;
      ST_POS: if (scl_in && elapsed(cnt_q, {{(TIME_W-WAIT_W){1'b0}}, cfg.wait_high})) begin
        case (op_q)
          OP_RSTART: begin st_d = ST_START; phase_d = 1'b0; end
          OP_STOP:   begin st_d = ST_STOP;  phase_d = 1'b0; end
          default:   st_d = ST_HIGH;
        endcase
      end
      ST_HIGH: begin
        if (parked_q) begin
          if (accept) begin
            st_d = ST_NEG; parked_d = 1'b0; op_d = bit_op_e'(req_op); bit_d = req_bit;
          end
        end else if (elapsed(cnt_q, cfg.high)) begin
          parked_d = 1'b1; done_d = 1'b1;
        end
      end
      ST_STOP: begin
        if (!phase_q) begin
          if (elapsed(cnt_q, cfg.stop_setup)) begin phase_d = 1'b1; pull_d = 1'b0; end
        end else if (elapsed(cnt_q, cfg.stop_hold)) begin
          st_d = ST_IDLE; done_d = 1'b1; parked_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (st_d != st_q || phase_d != phase_q) cnt_d = '0;
    else if (&cnt_q)                        cnt_d = cnt_q;
    else                                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_START;
      phase_q  <= 1'b0;
      parked_q <= 1'b0;
      bit_q    <= 1'b0;
      pull_q   <= 1'b0;
      done_q   <= 1'b0;
      rx_q     <= 1'b0;
      cnt_q    <= '0;
    end else begin
      st_q     <= st_d;
      op_q     <= op_d;
      phase_q  <= phase_d;
      parked_q <= parked_d;
      bit_q    <= bit_d;
      pull_q   <= pull_d;
      done_q   <= done_d;
      rx_q     <= rx_d;
      cnt_q    <= cnt_d;
    end
  end

  assign scl_oe = (st_q == ST_NEG) || (st_q == ST_LOW);
  assign sda_oe = pull_q;
  assign done   = done_q;
  assign rx_bit = rx_q;
  assign state  = st_q;
endmodule

// File: rtl/i2c_bit_timer_wdt.sv
module i2c_bit_timer_wdt
  import i2c_bit_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [ST_W-1:0]  state,
  input  logic [WDT_W-1:0] exp_sel,
  output logic             stuck
);
  logic [WDT_W-1:0] exp_eff;
  logic [WDC_W-1:0] lim_m1;
  logic [WDC_W-1:0] cnt_q, cnt_d;
  logic [ST_W-1:0]  prev_q;
  logic             stuck_q, stuck_d;

  assign exp_eff = (exp_sel > WDT_W'(WDT_MAX)) ? WDT_W'(WDT_MAX) : exp_sel;
  assign lim_m1  = (WDC_W'(1) << exp_eff) - WDC_W'(1);

  always_comb begin
    stuck_d = 1'b0;
    if (!active || state != prev_q) begin
      cnt_d = '0;
    end else if (cnt_q == lim_m1) begin
      cnt_d = '0; stuck_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      prev_q  <= '0;
      stuck_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      prev_q  <= state;
      stuck_q <= stuck_d;
    end
  end

  assign stuck = stuck_q;
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bit_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic              req_bit,
  output logic              req_ready,
  input  logic [TIME_W-1:0] cfg_hold,
  input  logic [TIME_W-1:0] cfg_low,
  input  logic [TIME_W-1:0] cfg_high,
  input  logic [TIME_W-1:0] cfg_sample,
  input  logic [TIME_W-1:0] cfg_start_hold,
  input  logic [TIME_W-1:0] cfg_rstart_setup,
  input  logic [TIME_W-1:0] cfg_stop_setup,
  input  logic [TIME_W-1:0] cfg_stop_hold,
  input  logic [WAIT_W-1:0] cfg_wait_high,
  input  logic              sample_on_low,
  input  logic [WDT_W-1:0]  wdt_exp,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              op_done,
  output logic              rx_bit,
  output logic [ST_W-1:0]   scl_state,
  output logic              stuck_pulse
);
  timing_t cfg;
  assign cfg.hold         = cfg_hold;
  assign cfg.low          = cfg_low;
  assign cfg.high         = cfg_high;
  assign cfg.sample       = cfg_sample;
  assign cfg.start_hold   = cfg_start_hold;
  assign cfg.rstart_setup = cfg_rstart_setup;
  assign cfg.stop_setup   = cfg_stop_setup;
  assign cfg.stop_hold    = cfg_stop_hold;
  assign cfg.wait_high    = cfg_wait_high;

  i2c_bit_timer_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_bit(req_bit),
    .cfg(cfg), .sample_on_low(sample_on_low), .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ready(req_ready), .done(op_done),
    .rx_bit(rx_bit), .state(scl_state)
  );

  i2c_bit_timer_wdt u_wdt (
    .clk(clk), .rst_n(rst_n), .active(!req_ready), .state(scl_state),
    .exp_sel(wdt_exp), .stuck(stuck_pulse)
  );
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       scl_in,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       op_done,
  input logic [2:0] scl_state
);
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    scl_state <= 3'd6);                                                            // R1
  AST_START_SCL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_state == 3'd1 |-> !scl_oe);                                                // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);                                                         // R3
  AST_NEG_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_state == 3'd2 && $past(scl_state) == 3'd2) |-> $stable(sda_oe));          // R4
  AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_state == 3'd4 && !scl_in) |=> scl_state == 3'd4);                         // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    scl_state == 3'd0 |-> (!scl_oe && !sda_oe));                                   // R10
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> req_ready);                                                        // R11
endmodule

bind i2c_bit_timer i2c_bit_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .scl_in(scl_in), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .op_done(op_done), .scl_state(scl_state)
);

// File: tb/i2c_bit_timer_tb_top.sv
module i2c_bit_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic req_bit = 1'b0;
  logic [8:0] c_hold = 9'd2, c_low = 9'd5, c_high = 9'd4, c_sample = 9'd2;
  logic [8:0] c_sth = 9'd3, c_rss = 9'd3, c_sps = 9'd3, c_sph = 9'd2;
  logic [6:0] c_wait = 7'd1;
  logic samp_low = 1'b0;
  logic [4:0] c_wdt = 5'd10;
  logic stretch = 1'b0, slv_lo = 1'b0, slv_hi = 1'b0;
  logic req_ready, scl_oe, sda_oe, op_done, rx_bit, stuck_pulse;
  logic [2:0] scl_state;
  logic scl_line, sda_line;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  assign scl_line = !(scl_oe || stretch);
  assign sda_line = !(sda_oe || (scl_line ? slv_hi : slv_lo));

  i2c_bit_timer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_bit(req_bit),
    .req_ready(req_ready), .cfg_hold(c_hold), .cfg_low(c_low), .cfg_high(c_high),
    .cfg_sample(c_sample), .cfg_start_hold(c_sth), .cfg_rstart_setup(c_rss),
    .cfg_stop_setup(c_sps), .cfg_stop_hold(c_sph), .cfg_wait_high(c_wait),
    .sample_on_low(samp_low), .wdt_exp(c_wdt), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .op_done(op_done), .rx_bit(rx_bit),
    .scl_state(scl_state), .stuck_pulse(stuck_pulse)
  );

  typedef struct {
    int    n_start, n_neg, n_low, n_pos, n_high, n_stop;
    bit    chk_rd, rd, sda, scl;
    int    st, to;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input string act, input string expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%s expected=%s", req, act, expv);
    end
  endtask

  function automatic exp_t mk(int s, int ng, int lw, int ps, int hi, int sp, bit chk_rd, bit rd,
                              bit sda, int st, int to, string tag);
    exp_t e;
    e.n_start = s; e.n_neg = ng; e.n_low = lw; e.n_pos = ps; e.n_high = hi; e.n_stop = sp;
    e.chk_rd = chk_rd; e.rd = rd; e.sda = sda; e.scl = 1'b0; e.st = st; e.to = to; e.tag = tag;
    return e;
  endfunction

  // Monitor: per-state cycle counts while working, compared on each done pulse.
  int c_st[7];
  int c_to = 0;
  bit neg_seen = 0, neg_chg = 0, neg_sda = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      foreach (c_st[i]) c_st[i] = 0;
      c_to = 0; neg_seen = 0; neg_chg = 0;
    end else begin
      if (!req_ready && scl_state <= 3'd6) c_st[scl_state]++;
      if (stuck_pulse) c_to++;
      if (scl_state == 3'd2) begin
        if (neg_seen && sda_oe != neg_sda) neg_chg = 1;
        neg_seen = 1; neg_sda = sda_oe;
      end
      if (op_done) begin
        if (exp_q.size() == 0) begin
          check(0, "R11 unexpected done", "done", "none");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(c_st[1] == e.n_start && c_st[2] == e.n_neg && c_st[3] == e.n_low &&
                c_st[4] == e.n_pos && c_st[5] == e.n_high && c_st[6] == e.n_stop,
                {e.tag, " phase lengths"},
                $sformatf("S%0d N%0d L%0d P%0d H%0d T%0d", c_st[1], c_st[2], c_st[3], c_st[4], c_st[5], c_st[6]),
                $sformatf("S%0d N%0d L%0d P%0d H%0d T%0d", e.n_start, e.n_neg, e.n_low, e.n_pos, e.n_high, e.n_stop));
          check(sda_oe == e.sda && scl_oe == e.scl && int'(scl_state) == e.st, {e.tag, " end lines"},
                $sformatf("sda_oe=%0d scl_oe=%0d st=%0d", sda_oe, scl_oe, scl_state),
                $sformatf("sda_oe=%0d scl_oe=%0d st=%0d", e.sda, e.scl, e.st));
          if (e.chk_rd) check(rx_bit == e.rd, {e.tag, " rx_bit"},
                              $sformatf("%0d", rx_bit), $sformatf("%0d", e.rd));
          check(c_to == e.to, {e.tag, " R12 stuck pulses"}, $sformatf("%0d", c_to), $sformatf("%0d", e.to));
          check(!neg_chg, {e.tag, " R4 sda held in negative edge"}, $sformatf("%0d", neg_chg), "0");
        end
        foreach (c_st[i]) c_st[i] = 0;
        c_to = 0; neg_seen = 0; neg_chg = 0;
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic b);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bit = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    forever begin
      @(negedge clk);
      if (op_done) break;
    end
  endtask

  task automatic run(input logic [2:0] op, input logic b, input exp_t e);
    exp_q.push_back(e);
    issue(op, b);
    wait_done();
  endtask

  task automatic summary();
    check(exp_q.size() == 0, "R3 all items completed", $sformatf("%0d", exp_q.size()), "0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(scl_state == 3'd0 && !scl_oe && !sda_oe && req_ready && !op_done && !stuck_pulse,
          "R1 reset state", $sformatf("st=%0d scl=%0d sda=%0d rdy=%0d", scl_state, scl_oe, sda_oe, req_ready),
          "st=0 scl=0 sda=0 rdy=1");

    // R11 WRITE in Idle ignored
    issue(3'd2, 1'b0);
    repeat (5) @(negedge clk);
    check(scl_state == 3'd0 && req_ready && !sda_oe, "R11 write ignored in Idle",
          $sformatf("st=%0d", scl_state), "st=0");

    // R2 START
    run(3'd0, 1'b0, mk(3, 0, 0, 0, 0, 0, 0, 0, 1, 5, 0, "R2 start"));

    // R11 START in parked High ignored
    issue(3'd0, 1'b0);
    repeat (5) @(negedge clk);
    check(scl_state == 3'd5 && req_ready && sda_oe && !scl_oe, "R11 start ignored when parked",
          $sformatf("st=%0d sda=%0d", scl_state, sda_oe), "st=5 sda=1");

    // R3 writes
    run(3'd2, 1'b1, mk(0, 2, 5, 1, 4, 0, 1, 1, 0, 5, 0, "R3 write one"));
    run(3'd2, 1'b0, mk(0, 2, 5, 1, 4, 0, 1, 0, 1, 5, 0, "R3 write zero"));

    // R5 reads, sampled in High
    slv_lo = 1'b1; slv_hi = 1'b0;
    run(3'd3, 1'b0, mk(0, 2, 5, 1, 4, 0, 1, 1, 0, 5, 0, "R5 read high-sample one"));
    slv_lo = 1'b1; slv_hi = 1'b1;
    run(3'd3, 1'b0, mk(0, 2, 5, 1, 4, 0, 1, 0, 0, 5, 0, "R5 read high-sample zero"));

    // R6 sample in Low
    samp_low = 1'b1; slv_lo = 1'b1; slv_hi = 1'b0;
    run(3'd3, 1'b0, mk(0, 2, 5, 1, 4, 0, 1, 0, 0, 5, 0, "R6 read low-sample"));
    samp_low = 1'b0; slv_lo = 1'b0; slv_hi = 1'b0;

    // R8 minimum wait in Positive edge
    c_wait = 7'd3;
    run(3'd2, 1'b1, mk(0, 2, 5, 3, 4, 0, 1, 1, 0, 5, 0, "R8 wait high"));
    c_wait = 7'd1;

    // R7 clock stretching for 6 cycles
    exp_q.push_back(mk(0, 2, 5, 6, 4, 0, 1, 1, 0, 5, 0, "R7 stretch"));
    stretch = 1'b1;
    issue(3'd2, 1'b1);
    begin
      int k = 0;
      while (stretch) begin
        @(negedge clk);
        if (scl_state == 3'd4) k++;
        if (k == 6) stretch = 1'b0;
      end
    end
    wait_done();

    // R9 repeated START
    run(3'd1, 1'b0, mk(6, 2, 5, 1, 0, 0, 0, 0, 1, 5, 0, "R9 repeated start"));

    // R12 watchdog: 2^3 cycles, Low of 20 cycles gives two pulses
    c_wdt = 5'd3; c_low = 9'd20;
    run(3'd2, 1'b0, mk(0, 2, 20, 1, 4, 0, 1, 0, 1, 5, 2, "R12 watchdog"));
    c_wdt = 5'd31;
    run(3'd2, 1'b0, mk(0, 2, 20, 1, 4, 0, 1, 0, 1, 5, 0, "R12 watchdog clamp"));
    c_wdt = 5'd10; c_low = 9'd5;

    // R10 STOP
    run(3'd4, 1'b0, mk(0, 2, 5, 1, 0, 5, 0, 0, 0, 0, 0, "R10 stop"));

    // R2 START again with a longer hold
    c_sth = 9'd5;
    run(3'd0, 1'b0, mk(5, 0, 0, 0, 0, 0, 0, 0, 1, 5, 0, "R2 start long hold"));

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule